// File: doc/BRIEF.md
# Buffered Configuration Port Transfer Engine

This peripheral sits between a host register bus and an on-chip configuration port. It owns a 512-word scratch buffer that the host can read and write directly. To push data into the port, the host fills part of the buffer, programs a byte count and a starting word index, and then writes 0 to the direction register. To pull data out of the port, the host programs the same two values and writes 1 instead. After launching a transfer, the host polls the done bit in the status word until the engine returns to idle. Once a readback has finished, the host drains the buffer.

The configuration port is modelled as two 32-bit word streams with valid/ready handshakes: one stream goes out of the engine and one comes in. The port also supplies four live flags, which the status word reports. A write of any value to the status register acts as a soft reset of the transfer logic. It abandons whatever transfer is running.

The sequencer has three states. ST_IDLE is the reset state and the only state in which done reads 1. ST_CONFIG streams buffer words out to the port. ST_READBACK stores incoming port words into the buffer. The transitions are as follows:
- The launch transition moves ST_IDLE to ST_CONFIG or ST_READBACK. It fires when the direction register is written while idle with a non-zero word count.
- The last-word transition returns to ST_IDLE on the handshake that moves the final word.
- The abort transition returns any state to ST_IDLE on a status-register write.

Top module: `cfg_xfer_engine`

## Requirements
- R1: Byte addresses below 0x800 reach the scratch buffer, with word n at byte address 4n. The bus read data shows the word addressed in the previous clock cycle.
- R2: The byte-count register is at 0x800. It keeps 12 bits and reads back zero-extended. The start-index register is at 0x804. It keeps 9 bits and reads back zero-extended. Both registers read 0 after reset.
- R3: Writing a value with bit 0 clear to 0x808 starts a configure transfer. Buffer words start..start+count/4-1 appear in order on the outgoing stream with valid high. Each word holds steady until ready is seen, and valid drops after the last word.
- R4: Writing a value with bit 0 set to 0x808 starts a readback transfer. The k-th word accepted from the incoming stream is stored at buffer word start+k, with ready high until the last word.
- R5: Reading 0x80C returns a status word with these bits:
  - bit 0 is done;
  - bits 1 to 4 are always 1;
  - bit 5 is the active-low abort flag;
  - bit 6 is the read-busy flag;
  - bit 7 is the aligned flag;
  - bit 8 is the error flag;
  - all higher bits are 0.
- R6: Done reads 1 after reset. It clears from the cycle after a transfer is launched and reads 1 again once the last word has been moved.
- R7: The two low bits of the byte count are ignored. A count below 4 launches nothing: done stays 1 and neither stream handshakes.
- R8: A direction-register write during a busy transfer is ignored. The running transfer keeps its direction and moves exactly its programmed number of words.
- R9: Any write to 0x80C returns the engine to idle with done set. If an incoming word is offered in the same cycle, that word is discarded and the buffer word keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Host byte address |
| bus_we | input | 1 | Host write strobe |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, one cycle after the address |
| cp_out_data | output | 32 | Outgoing port word (configure) |
| cp_out_valid | output | 1 | Outgoing word valid |
| cp_out_ready | input | 1 | Port accepts outgoing word |
| cp_in_data | input | 32 | Incoming port word (readback) |
| cp_in_valid | input | 1 | Incoming word valid |
| cp_in_ready | output | 1 | Engine accepts incoming word |
| port_abort_n | input | 1 | Port abort flag, active low |
| port_reading | input | 1 | Port read-busy flag |
| port_aligned | input | 1 | Port aligned flag |
| port_error | input | 1 | Port error flag |

## Verification
The soft-reset write and a port handshake can land on the same clock edge. The bench provokes this by writing 0x80C in the very cycle in which it offers a readback word with the engine ready. The abort must win: the engine has to be idle on the next cycle, and the targeted buffer word must still hold its pre-filled value when read back over the bus. A matching case aborts a stalled configure transfer and confirms that the outgoing valid drops at once.

// File: rtl/cfg_xfer_pkg.sv
package cfg_xfer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_CONFIG   = 2'd1,
        ST_READBACK = 2'd2
    } xfer_state_e;

    // register select taken from byte address bits [3:2] inside the register window
    localparam logic [1:0] SEL_COUNT  = 2'd0;
    localparam logic [1:0] SEL_START  = 2'd1;
    localparam logic [1:0] SEL_DIR    = 2'd2;
    localparam logic [1:0] SEL_STATUS = 2'd3;

    localparam int STATUS_ONES_W = 4;
    localparam int FLAG_W        = 4;

endpackage

// File: rtl/cfg_xfer_buffer.sv
module cfg_xfer_buffer #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IDX_W-1:0] raddr_host,
    output logic [WIDTH-1:0] rdata_host,
    input  logic [IDX_W-1:0] raddr_port,
    output logic [WIDTH-1:0] rdata_port
);

    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata_host = mem_q[raddr_host];
    assign rdata_port = mem_q[raddr_port];

endmodule

// File: rtl/cfg_xfer_regs.sv
module cfg_xfer_regs
    import cfg_xfer_pkg::*;
#(
    parameter int IDX_W  = 9,
    parameter int WIDTH  = 32,
    localparam int ADDR_W = IDX_W + 3,
    localparam int SIZE_W = IDX_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  buf_rdata,
    output logic [IDX_W-1:0]  buf_raddr,
    output logic              host_we,
    output logic [IDX_W-1:0]  host_waddr,
    output logic [WIDTH-1:0]  host_wdata,
    output logic [SIZE_W-1:0] count_q,
    output logic [IDX_W-1:0]  start_q,
    output logic              launch_req,
    output logic              launch_dir,
    output logic              soft_rst,
    input  logic              done,
    input  logic [FLAG_W-1:0] port_flags
);

    logic             in_reg_window;
    logic [1:0]       sel;
    logic [WIDTH-1:0] rdata_d;
    logic             addr_unused;

    assign in_reg_window = bus_addr[ADDR_W-1];
    assign sel           = bus_addr[3:2];
    assign addr_unused   = ^bus_addr[1:0];

    assign buf_raddr  = bus_addr[IDX_W+1:2];
    assign host_waddr = bus_addr[IDX_W+1:2];
    assign host_wdata = bus_wdata;
    assign host_we    = bus_we && !in_reg_window;

    assign launch_req = bus_we && in_reg_window && (sel == SEL_DIR);
    assign launch_dir = bus_wdata[0];
    assign soft_rst   = bus_we && in_reg_window && (sel == SEL_STATUS);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            start_q <= '0;
        end else if (bus_we && in_reg_window) begin
            if (sel == SEL_COUNT) begin
                count_q <= bus_wdata[SIZE_W-1:0];
            end
            if (sel == SEL_START) begin
                start_q <= bus_wdata[IDX_W-1:0];
            end
        end
    end

    always_comb begin
        rdata_d = '0;
        if (!in_reg_window) begin
            rdata_d = buf_rdata;
        end else begin
            unique case (sel)
                SEL_COUNT:  rdata_d = WIDTH'(count_q);
                SEL_START:  rdata_d = WIDTH'(start_q);
                SEL_DIR:    rdata_d = '0;
                SEL_STATUS: rdata_d = WIDTH'({port_flags, {STATUS_ONES_W{1'b1}}, done});
                default:    rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= rdata_d;
        end
    end

endmodule

// File: rtl/cfg_xfer_seq.sv
module cfg_xfer_seq
    import cfg_xfer_pkg::*;
#(
    parameter int IDX_W = 9,
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch_req,
    input  logic             launch_dir,
    input  logic [CNT_W-1:0] size_words,
    input  logic [IDX_W-1:0] start_idx,
    input  logic             soft_rst,
    input  logic             cp_out_ready,
    input  logic             cp_in_valid,
    output logic             cp_out_valid,
    output logic             cp_in_ready,
    output logic             done,
    output logic             eng_we,
    output logic [IDX_W-1:0] ptr
);

    xfer_state_e      state_q, state_d;
    logic [IDX_W-1:0] ptr_q;
    logic [CNT_W-1:0] remain_q;
    logic             launch;
    logic             beat;
    logic             last_beat;

    assign launch    = (state_q == ST_IDLE) && launch_req && (size_words != '0);
    assign last_beat = beat && (remain_q == CNT_W'(1));
    assign ptr       = ptr_q;

    always_comb begin
        unique case (state_q)
            ST_CONFIG:   beat = cp_out_ready;
            ST_READBACK: beat = cp_in_valid;
            default:     beat = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: launch, last-word, abort
    always_comb begin
        state_d = state_q;
        if (soft_rst) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     if (launch)    state_d = launch_dir ? ST_READBACK : ST_CONFIG;
                ST_CONFIG:   if (last_beat) state_d = ST_IDLE;
                ST_READBACK: if (last_beat) state_d = ST_IDLE;
                default:                    state_d = ST_IDLE;
            endcase
        end
    end

    // word pointer and remaining count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            remain_q <= '0;
        end else if (!soft_rst) begin
            if (launch) begin
                ptr_q    <= start_idx;
                remain_q <= size_words;
            end else if (beat) begin
                ptr_q    <= ptr_q + IDX_W'(1);
                remain_q <= remain_q - CNT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        done         = 1'b0;
        cp_out_valid = 1'b0;
        cp_in_ready  = 1'b0;
        eng_we       = 1'b0;
        unique case (state_q)
            ST_IDLE:     done = 1'b1;
            ST_CONFIG:   cp_out_valid = 1'b1;
            ST_READBACK: begin
                cp_in_ready = 1'b1;
                eng_we      = cp_in_valid && !soft_rst;
            end
            default:     done = 1'b1;
        endcase
    end

    a_r3_r4_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(cp_out_valid && cp_in_ready));

    a_r3_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_out_valid && !cp_out_ready && !soft_rst) |=> (cp_out_valid && $stable(ptr_q)));

    a_r6_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (done && launch_req && (size_words != '0) && !soft_rst) |=> !done);

    a_r7_empty_stays_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done && launch_req && (size_words == '0)) |=> (done && !cp_out_valid && !cp_in_ready));

    a_r8_busy_keeps_direction: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_out_valid && !cp_out_ready && launch_req && !soft_rst) |=> (cp_out_valid && !cp_in_ready));

    a_r9_abort_idles: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (done && !cp_out_valid && !cp_in_ready));

    a_r9_no_store_on_abort: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> !eng_we);

endmodule

// File: rtl/cfg_xfer_engine.sv
module cfg_xfer_engine
    import cfg_xfer_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int WIDTH = 32,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int ADDR_W = IDX_W + 3,
    localparam int SIZE_W = IDX_W + 3,
    localparam int CNT_W  = SIZE_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    output logic [WIDTH-1:0]  cp_out_data,
    output logic              cp_out_valid,
    input  logic              cp_out_ready,
    input  logic [WIDTH-1:0]  cp_in_data,
    input  logic              cp_in_valid,
    output logic              cp_in_ready,
    input  logic              port_abort_n,
    input  logic              port_reading,
    input  logic              port_aligned,
    input  logic              port_error
);

    logic [WIDTH-1:0]  buf_rdata;
    logic [IDX_W-1:0]  buf_raddr;
    logic              host_we;
    logic [IDX_W-1:0]  host_waddr;
    logic [WIDTH-1:0]  host_wdata;
    logic [SIZE_W-1:0] count_q;
    logic [IDX_W-1:0]  start_q;
    logic              launch_req;
    logic              launch_dir;
    logic              soft_rst;
    logic              done;
    logic              eng_we;
    logic [IDX_W-1:0]  ptr;
    logic              mem_we;
    logic [IDX_W-1:0]  mem_waddr;
    logic [WIDTH-1:0]  mem_wdata;
    logic              count_unused;

    assign count_unused = ^count_q[1:0];

    // engine stores take the single write port ahead of host stores
    assign mem_we    = eng_we || host_we;
    assign mem_waddr = eng_we ? ptr : host_waddr;
    assign mem_wdata = eng_we ? cp_in_data : host_wdata;

    cfg_xfer_regs #(.IDX_W(IDX_W), .WIDTH(WIDTH)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .buf_rdata  (buf_rdata),
        .buf_raddr  (buf_raddr),
        .host_we    (host_we),
        .host_waddr (host_waddr),
        .host_wdata (host_wdata),
        .count_q    (count_q),
        .start_q    (start_q),
        .launch_req (launch_req),
        .launch_dir (launch_dir),
        .soft_rst   (soft_rst),
        .done       (done),
        .port_flags ({port_error, port_aligned, port_reading, port_abort_n})
    );

    cfg_xfer_seq #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch_req   (launch_req),
        .launch_dir   (launch_dir),
        .size_words   (count_q[SIZE_W-1:2]),
        .start_idx    (start_q),
        .soft_rst     (soft_rst),
        .cp_out_ready (cp_out_ready),
        .cp_in_valid  (cp_in_valid),
        .cp_out_valid (cp_out_valid),
        .cp_in_ready  (cp_in_ready),
        .done         (done),
        .eng_we       (eng_we),
        .ptr          (ptr)
    );

    cfg_xfer_buffer #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_buf (
        .clk        (clk),
        .we         (mem_we),
        .waddr      (mem_waddr),
        .wdata      (mem_wdata),
        .raddr_host (buf_raddr),
        .rdata_host (buf_rdata),
        .raddr_port (ptr),
        .rdata_port (cp_out_data)
    );

endmodule

// File: tb/cfg_xfer_engine_bench.sv
`timescale 1ns/1ps
module cfg_xfer_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] cp_out_data;
    logic        cp_out_valid;
    logic        cp_out_ready;
    logic [31:0] cp_in_data;
    logic        cp_in_valid;
    logic        cp_in_ready;
    logic        port_abort_n;
    logic        port_reading;
    logic        port_aligned;
    logic        port_error;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    cfg_xfer_engine u_cfg_xfer_engine (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cp_out_data(cp_out_data), .cp_out_valid(cp_out_valid), .cp_out_ready(cp_out_ready),
        .cp_in_data(cp_in_data), .cp_in_valid(cp_in_valid), .cp_in_ready(cp_in_ready),
        .port_abort_n(port_abort_n), .port_reading(port_reading),
        .port_aligned(port_aligned), .port_error(port_error)
    );

    typedef struct packed {
        logic        dir;
        logic [8:0]  off;
        logic [11:0] nbytes;
        logic [7:0]  stall;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 9'd0,   12'd16, 8'h00},
        '{1'b0, 9'd508, 12'd16, 8'h55},
        '{1'b1, 9'd20,  12'd23, 8'h30},
        '{1'b1, 9'd511, 12'd4,  8'h01},
        '{1'b0, 9'd100, 12'd6,  8'h01}
    };

    function automatic logic [31:0] pat(input int c, input int k);
        return {8'(c + 1), 8'hA5, 16'(k * 7 + 3)};
    endfunction

    function automatic logic [31:0] st_exp(input logic d);
        return {23'd0, port_error, port_aligned, port_reading, port_abort_n, 4'hF, d};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_we    = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        bus_we   = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    function automatic logic [11:0] waddr(input int idx);
        return 12'((idx % 512) * 4);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int n;
        rst_n = 1'b0;
        bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
        cp_out_ready = 1'b0; cp_in_valid = 1'b0; cp_in_data = '0;
        port_abort_n = 1'b1; port_reading = 1'b0; port_aligned = 1'b0; port_error = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd(12'h800, r); chk("R2 reset count", r, 32'h0);
        rd(12'h804, r); chk("R2 reset start", r, 32'h0);
        rd(12'h80C, r); chk("R6 R5 reset status", r, st_exp(1'b1));
        chk("R3 idle out valid", {31'd0, cp_out_valid}, 32'd0);
        chk("R4 idle in ready", {31'd0, cp_in_ready}, 32'd0);

        // R1 buffer access
        wr(12'h000, 32'h1234_5678);
        wr(12'h7FC, 32'hCAFE_F00D);
        rd(12'h000, r); chk("R1 word 0", r, 32'h1234_5678);
        rd(12'h7FC, r); chk("R1 word 511", r, 32'hCAFE_F00D);

        // R2 register widths
        wr(12'h800, 32'hFFFF_FFFF);
        rd(12'h800, r); chk("R2 count width", r, 32'h0000_0FFF);
        wr(12'h804, 32'hFFFF_F2AB);
        rd(12'h804, r); chk("R2 start width", r, 32'h0000_00AB);

        // R5 flag positions
        port_abort_n = 1'b0; port_reading = 1'b1; port_aligned = 1'b0; port_error = 1'b1;
        rd(12'h80C, r); chk("R5 flags a", r, 32'h0000_015F);
        port_abort_n = 1'b1; port_reading = 1'b0; port_aligned = 1'b1; port_error = 1'b0;
        rd(12'h80C, r); chk("R5 flags b", r, 32'h0000_00BF);

        // table-driven transfers
        for (int i = 0; i < NVEC; i++) begin
            n = int'(VECS[i].nbytes >> 2);
            if (!VECS[i].dir) begin
                for (int k = 0; k < n; k++) wr(waddr(int'(VECS[i].off) + k), pat(i, k));
            end
            wr(12'h800, 32'(VECS[i].nbytes));
            wr(12'h804, 32'(VECS[i].off));
            wr(12'h808, {31'd0, VECS[i].dir});
            if (!VECS[i].dir) begin
                for (int k = 0; k < n; k++) begin
                    if (VECS[i].stall[k % 8]) begin
                        cp_out_ready = 1'b0;
                        @(negedge clk);
                    end
                    cp_out_ready = 1'b1;
                    chk("R3 out valid", {31'd0, cp_out_valid}, 32'd1);
                    chk("R3 out data", cp_out_data, pat(i, k));
                    @(negedge clk);
                end
                cp_out_ready = 1'b0;
                chk("R3 valid drops after last", {31'd0, cp_out_valid}, 32'd0);
            end else begin
                for (int k = 0; k < n; k++) begin
                    if (VECS[i].stall[k % 8]) begin
                        cp_in_valid = 1'b0;
                        @(negedge clk);
                    end
                    cp_in_valid = 1'b1;
                    cp_in_data  = pat(i, k);
                    chk("R4 in ready", {31'd0, cp_in_ready}, 32'd1);
                    @(negedge clk);
                end
                cp_in_valid = 1'b0;
                chk("R4 ready drops after last", {31'd0, cp_in_ready}, 32'd0);
                for (int k = 0; k < n; k++) begin
                    rd(waddr(int'(VECS[i].off) + k), r);
                    chk("R4 stored word", r, pat(i, k));
                end
            end
            rd(12'h80C, r); chk("R6 done after transfer", r, st_exp(1'b1));
        end

        // R7 count below one word
        wr(12'h800, 32'd3);
        wr(12'h808, 32'd0);
        chk("R7 no outgoing word", {31'd0, cp_out_valid}, 32'd0);
        rd(12'h80C, r); chk("R7 done stays set", r, st_exp(1'b1));

        // R6 and R8: launch clears done, direction write while busy ignored
        for (int k = 0; k < 3; k++) wr(waddr(60 + k), pat(9, k));
        wr(12'h800, 32'd12);
        wr(12'h804, 32'd60);
        wr(12'h808, 32'd0);
        rd(12'h80C, r); chk("R6 done cleared while busy", r, st_exp(1'b0));
        wr(12'h808, 32'd1);
        chk("R8 still configuring", {31'd0, cp_out_valid}, 32'd1);
        chk("R8 no readback", {31'd0, cp_in_ready}, 32'd0);
        n = 0;
        cp_out_ready = 1'b1;
        while (cp_out_valid && n < 10) begin
            chk("R8 data", cp_out_data, pat(9, n));
            n++;
            @(negedge clk);
        end
        cp_out_ready = 1'b0;
        chk("R8 word count", 32'(n), 32'd3);

        // R9 abort coinciding with a readback handshake
        for (int k = 0; k < 4; k++) wr(waddr(40 + k), 32'h1111_0000 + 32'(k));
        wr(12'h800, 32'd16);
        wr(12'h804, 32'd40);
        wr(12'h808, 32'd1);
        for (int k = 0; k < 2; k++) begin
            cp_in_valid = 1'b1;
            cp_in_data  = pat(7, k);
            @(negedge clk);
        end
        cp_in_valid = 1'b1;
        cp_in_data  = 32'h9999_9999;
        bus_addr = 12'h80C; bus_we = 1'b1; bus_wdata = 32'h0;
        @(negedge clk);
        bus_we = 1'b0;
        cp_in_valid = 1'b0;
        chk("R9 readback aborted", {31'd0, cp_in_ready}, 32'd0);
        rd(waddr(41), r); chk("R9 word before abort", r, pat(7, 1));
        rd(waddr(42), r); chk("R9 word at abort kept", r, 32'h1111_0002);
        rd(12'h80C, r); chk("R9 done after abort", r, st_exp(1'b1));

        // R9 abort of a stalled configure transfer
        wr(12'h800, 32'd8);
        wr(12'h804, 32'd0);
        wr(12'h808, 32'd0);
        chk("R9 configure running", {31'd0, cp_out_valid}, 32'd1);
        wr(12'h80C, 32'h0000_FEFE);
        chk("R9 configure aborted", {31'd0, cp_out_valid}, 32'd0);
        rd(12'h80C, r); chk("R9 done after configure abort", r, st_exp(1'b1));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule